// File: doc/BRIEF.md
# Channel-Group Control and Power Sequencer

This block governs a group of two echo-canceller channels from one 8-bit control byte. The byte carries the group's power request, its companding law, its PCM coding and one tone-interrupt mask per channel. The law and coding settings reach both channels together. The two tone-detector interrupts are gated by their masks before they leave the block.

The power bit drives a small sequencer. Setting the bit from 0 to 1 starts an initialization. On that edge a window of per-channel registers (64 offsets for each channel) returns to its defaults, and a coefficient-clear request goes to the adaptive filters. Both stay in force until two frame strobes have passed. While the group is powered down, each channel's receive and send samples bypass the cancellers through a frame-aligned pipeline that delays them by two frames. Clearing the power bit stops processing at once and aborts any initialization in progress. The path switches to bypass at the next frame strobe.

Software reaches the control byte and the register window over a simple bus. Writes take effect on the clock edge and reads are combinational. An address with bit 7 clear selects the control byte. With bit 7 set, bit 6 selects the channel and bits 5:0 give the window offset.

Top module: `chgrp_ctrl`

## Requirements
- R1: After reset the control byte reads 0x00, `init_busy` is 0, `bypass_on` is 1, `ch_active` is 0, `alaw_sel` is 0 and `g711_sel` is 0.
- R2: Control bit 1 drives `alaw_sel` and bit 2 drives `g711_sel`. Each is a single output shared by both channels. Bit 0 is the power request.
- R3: Control bits 7:5 always read 0, and writing ones to them has no effect on any output.
- R4: `tone_irq_out[0]` equals `tone_irq_in[0]` unless control bit 3 is set, and `tone_irq_out[1]` equals `tone_irq_in[1]` unless control bit 4 is set. A set bit forces the output to 0.
- R5: While `bypass_on` is 1, each `rout`/`sout` lane shows the `rin`/`sin` value that was present at the previous-but-one frame strobe. A value applied at strobe k appears after strobe k+1 and holds until strobe k+2.
- R6: Within two clocks of a write that moves the power bit from 0 to 1, `init_busy` and both `coef_clr` bits go to 1. At that point every window register reads its default: bit 7 set and the low bits equal to the offset (offset 5 reads 0x85, offset 63 reads 0xBF).
- R7: `init_busy` falls on the second frame strobe after initialization starts. `ch_active` is then 1 for both channels.
- R8: Window writes are stored and read back at address {1, channel, offset}, except while `init_busy` is 1. Writes in that state are ignored.
- R9: Within two clocks of clearing the power bit, `init_busy` and `ch_active` fall, even in mid-initialization. `bypass_on` stays 0 until the next frame strobe and becomes 1 at it.
- R10: While `bypass_on` is 0, `rout` and `sout` carry `ec_rout` and `ec_sout` unchanged.
- R11: `bypass_on` changes only on a frame strobe. After power is set, it falls at the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the bus |
| bus_addr | input | 8 | Bus address: control byte or {1, channel, offset} |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| frame_stb | input | 1 | One-clock pulse per PCM frame |
| rin | input | 2x8 | Receive-path samples in, per channel |
| sin | input | 2x8 | Send-path samples in, per channel |
| ec_rout | input | 2x8 | Processed receive samples from the cancellers |
| ec_sout | input | 2x8 | Processed send samples from the cancellers |
| rout | output | 2x8 | Receive-path samples out |
| sout | output | 2x8 | Send-path samples out |
| tone_irq_in | input | 2 | Raw tone-detector interrupts, per channel |
| tone_irq_out | output | 2 | Masked tone interrupts |
| alaw_sel | output | 1 | A-law (1) or μ-law (0) for both channels |
| g711_sel | output | 1 | G.711 coding (1) or sign-magnitude (0) for both channels |
| ch_active | output | 2 | Channel processing enabled |
| coef_clr | output | 2 | Clear request to each channel's coefficient store |
| init_busy | output | 1 | Initialization in progress |
| bypass_on | output | 1 | PCM bypass path selected |

## Verification
The bench builds the block with its default parameters: 8-bit samples, a 6-bit window offset and a two-frame initialization. Under these values an offset-63 access reaches the top of each channel's window. The two-frame delay can be followed sample by sample across four strobes. An abort can be placed between the first and the second strobe of an initialization, which is the only point where the sequencer sits half-way.

// File: rtl/chgrp_pkg.sv
package chgrp_pkg;

    localparam int GRP_CH     = 2;
    localparam int CTRL_BITS  = 5;
    localparam int CTRL_BYTE  = 8;

    typedef struct packed {
        logic mask_b;
        logic mask_a;
        logic g711;
        logic alaw;
        logic pwr;
    } grp_ctrl_t;

    typedef enum logic [1:0] {
        SEQ_OFF  = 2'd0,
        SEQ_INIT = 2'd1,
        SEQ_RUN  = 2'd2
    } seq_state_e;

    function automatic logic [CTRL_BYTE-1:0] ctrl_to_byte(input grp_ctrl_t c);
        return {{(CTRL_BYTE-CTRL_BITS){1'b0}}, c};
    endfunction

    function automatic grp_ctrl_t byte_to_ctrl(input logic [CTRL_BYTE-1:0] b);
        return grp_ctrl_t'(b[CTRL_BITS-1:0]);
    endfunction

    function automatic logic [GRP_CH-1:0] ctrl_masks(input grp_ctrl_t c);
        return {c.mask_b, c.mask_a};
    endfunction

endpackage

// File: rtl/chgrp_power_seq.sv
module chgrp_power_seq
    import chgrp_pkg::*;
#(
    parameter int FRAMES = 2,
    localparam int CW = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_req,
    input  logic frame_stb,
    output logic preset,
    output logic init_busy,
    output logic running,
    output logic bypass_on
);

    seq_state_e      state_q;
    logic [CW-1:0]   fcnt_q;
    logic            pwr_d_q;
    logic            byp_q;
    logic            rise;

    assign rise = pwr_req & ~pwr_d_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_OFF;
            fcnt_q  <= '0;
            pwr_d_q <= 1'b0;
            byp_q   <= 1'b1;
        end else begin
            pwr_d_q <= pwr_req;
            if (frame_stb) begin
                byp_q <= ~pwr_req;
            end
            if (!pwr_req) begin
                state_q <= SEQ_OFF;
                fcnt_q  <= '0;
            end else if (rise) begin
                state_q <= SEQ_INIT;
                fcnt_q  <= '0;
            end else if (state_q == SEQ_INIT && frame_stb) begin
                if (fcnt_q == CW'(FRAMES - 1)) begin
                    state_q <= SEQ_RUN;
                    fcnt_q  <= '0;
                end else begin
                    fcnt_q  <= fcnt_q + 1'b1;
                end
            end
        end
    end

    assign preset    = rise;
    assign init_busy = (state_q == SEQ_INIT);
    assign running   = (state_q == SEQ_RUN);
    assign bypass_on = byp_q;

endmodule

// File: rtl/chgrp_win_regs.sv
module chgrp_win_regs #(
    parameter int NCH   = 2,
    parameter int WIN_W = 6,
    parameter int DW    = 8,
    localparam int DEPTH = 1 << WIN_W,
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             preset,
    input  logic             wr_en,
    input  logic [CH_W-1:0]  ch,
    input  logic [WIN_W-1:0] off,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);

    logic [DW-1:0] mem_q [NCH][DEPTH];

    function automatic logic [DW-1:0] dflt(input int unsigned o);
        return DW'(o) | (DW'(1) << (DW - 1));
    endfunction

    always_ff @(posedge clk) begin
        if (rst || preset) begin
            for (int c = 0; c < NCH; c++) begin
                for (int o = 0; o < DEPTH; o++) begin
                    mem_q[c][o] <= dflt(o);
                end
            end
        end else if (wr_en) begin
            mem_q[ch][off] <= wdata;
        end
    end

    assign rdata = mem_q[ch][off];

endmodule

// File: rtl/chgrp_frame_delay.sv
module chgrp_frame_delay #(
    parameter int DW     = 8,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);

    logic [DW-1:0] pipe_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) begin
                pipe_q[s] <= '0;
            end
        end else if (adv) begin
            pipe_q[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/chgrp_ctrl.sv
module chgrp_ctrl
    import chgrp_pkg::*;
#(
    parameter int DW     = 8,
    parameter int WIN_W  = 6,
    parameter int FRAMES = 2,
    localparam int NCH    = GRP_CH,
    localparam int CH_W   = $clog2(NCH),
    localparam int ADDR_W = WIN_W + CH_W + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [7:0]               bus_wdata,
    output logic [7:0]               bus_rdata,
    input  logic                     frame_stb,
    input  logic [NCH-1:0][DW-1:0]   rin,
    input  logic [NCH-1:0][DW-1:0]   sin,
    input  logic [NCH-1:0][DW-1:0]   ec_rout,
    input  logic [NCH-1:0][DW-1:0]   ec_sout,
    output logic [NCH-1:0][DW-1:0]   rout,
    output logic [NCH-1:0][DW-1:0]   sout,
    input  logic [NCH-1:0]           tone_irq_in,
    output logic [NCH-1:0]           tone_irq_out,
    output logic                     alaw_sel,
    output logic                     g711_sel,
    output logic [NCH-1:0]           ch_active,
    output logic [NCH-1:0]           coef_clr,
    output logic                     init_busy,
    output logic                     bypass_on
);

    grp_ctrl_t      ctrl_q;
    logic [7:0]     ctrl_byte;
    logic           sel_win;
    logic           preset;
    logic           running;
    logic           win_wr;
    logic [7:0]     win_rdata;
    logic [NCH-1:0] masks;

    assign sel_win   = bus_addr[ADDR_W-1];
    assign ctrl_byte = ctrl_to_byte(ctrl_q);
    assign masks     = ctrl_masks(ctrl_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (bus_wr && !sel_win) begin
            ctrl_q <= byte_to_ctrl(bus_wdata);
        end
    end

    chgrp_power_seq #(.FRAMES(FRAMES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .pwr_req   (ctrl_q.pwr),
        .frame_stb (frame_stb),
        .preset    (preset),
        .init_busy (init_busy),
        .running   (running),
        .bypass_on (bypass_on)
    );

    assign win_wr = bus_wr && sel_win && !init_busy;

    chgrp_win_regs #(.NCH(NCH), .WIN_W(WIN_W), .DW(8)) u_win (
        .clk    (clk),
        .rst    (rst),
        .preset (preset),
        .wr_en  (win_wr),
        .ch     (bus_addr[WIN_W +: CH_W]),
        .off    (bus_addr[WIN_W-1:0]),
        .wdata  (bus_wdata),
        .rdata  (win_rdata)
    );

    assign bus_rdata = sel_win ? win_rdata : ctrl_byte;

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_ch
            logic [DW-1:0] r_dly;
            logic [DW-1:0] s_dly;

            chgrp_frame_delay #(.DW(DW), .STAGES(2)) u_rdly (
                .clk  (clk),
                .rst  (rst),
                .adv  (frame_stb),
                .din  (rin[g]),
                .dout (r_dly)
            );

            chgrp_frame_delay #(.DW(DW), .STAGES(2)) u_sdly (
                .clk  (clk),
                .rst  (rst),
                .adv  (frame_stb),
                .din  (sin[g]),
                .dout (s_dly)
            );

            assign rout[g]         = bypass_on ? r_dly : ec_rout[g];
            assign sout[g]         = bypass_on ? s_dly : ec_sout[g];
            assign tone_irq_out[g] = tone_irq_in[g] & ~masks[g];
            assign ch_active[g]    = running;
            assign coef_clr[g]     = init_busy;
        end
    endgenerate

    assign alaw_sel = ctrl_q.alaw;
    assign g711_sel = ctrl_q.g711;

endmodule

// File: rtl/chgrp_ctrl_chk.sv
module chgrp_ctrl_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_stb,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_rdata,
    input logic [7:0]        ctrl_byte,
    input logic [1:0]        tone_irq_out,
    input logic [1:0]        ch_active,
    input logic              init_busy,
    input logic              bypass_on
);

    // R3
    unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_addr[ADDR_W-1] |-> bus_rdata[7:5] == 3'b000);

    // R4
    mask_a_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_byte[3] |-> !tone_irq_out[0]);

    // R4
    mask_b_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_byte[4] |-> !tone_irq_out[1]);

    // R6
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(init_busy) |-> ctrl_byte[0]);

    // R7
    busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(init_busy) |-> ($past(frame_stb) || !ctrl_byte[0]));

    // R7
    active_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(init_busy && ch_active[0]));

    // R11
    bypass_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(bypass_on) |-> $past(frame_stb));

endmodule

bind chgrp_ctrl chgrp_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .frame_stb    (frame_stb),
    .bus_addr     (bus_addr),
    .bus_rdata    (bus_rdata),
    .ctrl_byte    (ctrl_byte),
    .tone_irq_out (tone_irq_out),
    .ch_active    (ch_active),
    .init_busy    (init_busy),
    .bypass_on    (bypass_on)
);

// File: tb/chgrp_ctrl_test.sv
module chgrp_ctrl_test;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_wr = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic [7:0]      bus_wdata = '0;
    logic [7:0]      bus_rdata;
    logic            frame_stb = 1'b0;
    logic [1:0][7:0] rin = '0, sin = '0, ec_rout = '0, ec_sout = '0;
    logic [1:0][7:0] rout, sout;
    logic [1:0]      tone_irq_in = '0;
    logic [1:0]      tone_irq_out;
    logic            alaw_sel, g711_sel, init_busy, bypass_on;
    logic [1:0]      ch_active, coef_clr;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    chgrp_ctrl uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_stb(frame_stb),
        .rin(rin), .sin(sin), .ec_rout(ec_rout), .ec_sout(ec_sout),
        .rout(rout), .sout(sout), .tone_irq_in(tone_irq_in),
        .tone_irq_out(tone_irq_out), .alaw_sel(alaw_sel), .g711_sel(g711_sel),
        .ch_active(ch_active), .coef_clr(coef_clr), .init_busy(init_busy),
        .bypass_on(bypass_on)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic strobe();
        @(negedge clk);
        frame_stb = 1'b1;
        @(negedge clk);
        frame_stb = 1'b0;
        #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        bus_read(8'h00, d);
        check("R1 ctrl byte", d, 8'h00);
        check("R1 init_busy", init_busy, 0);
        check("R1 bypass_on", bypass_on, 1);
        check("R1 ch_active", ch_active, 0);
        check("R1 law/format", {alaw_sel, g711_sel}, 0);
    endtask

    task automatic t_fields();
        logic [7:0] d;
        bus_write(8'h00, 8'hE6);
        bus_read(8'h00, d);
        check("R3 unused bits read 0", d, 8'h06);
        check("R2 alaw_sel", alaw_sel, 1);
        check("R2 g711_sel", g711_sel, 1);
        check("R3 no power effect", {init_busy, ch_active}, 0);
        bus_write(8'h00, 8'hE2);
        check("R2 alaw only", {alaw_sel, g711_sel}, 2'b10);
        bus_write(8'h00, 8'h00);
    endtask

    task automatic t_mask();
        tone_irq_in = 2'b11;
        bus_write(8'h00, 8'h08);
        #1 check("R4 mask A", tone_irq_out, 2'b10);
        bus_write(8'h00, 8'h10);
        #1 check("R4 mask B", tone_irq_out, 2'b01);
        bus_write(8'h00, 8'h18);
        #1 check("R4 mask both", tone_irq_out, 2'b00);
        bus_write(8'h00, 8'h00);
        #1 check("R4 unmasked", tone_irq_out, 2'b11);
        tone_irq_in = 2'b01;
        #1 check("R4 follows input", tone_irq_out, 2'b01);
        tone_irq_in = 2'b00;
    endtask

    task automatic t_bypass();
        ec_rout = {8'hE1, 8'hE0};
        ec_sout = {8'hF1, 8'hF0};
        for (int k = 0; k < 4; k++) begin
            rin = {8'(8'h20 + k), 8'(8'h10 + k)};
            sin = {8'(8'h40 + k), 8'(8'h30 + k)};
            strobe();
            if (k >= 1) begin
                check("R5 rout delay", rout, {8'(8'h20 + k - 1), 8'(8'h10 + k - 1)});
                check("R5 sout delay", sout, {8'(8'h40 + k - 1), 8'(8'h30 + k - 1)});
            end
        end
        idle(3);
        check("R5 holds between strobes", rout, {8'h22, 8'h12});
    endtask

    task automatic t_window();
        logic [7:0] d;
        bus_write(8'h85, 8'h33);
        bus_write(8'hFF, 8'h44);
        bus_read(8'h85, d);
        check("R8 ch0 off5 write", d, 8'h33);
        bus_read(8'hFF, d);
        check("R8 ch1 off63 write", d, 8'h44);
    endtask

    task automatic t_powerup();
        logic [7:0] d;
        bus_write(8'h00, 8'h01);
        idle(2);
        check("R6 init_busy", init_busy, 1);
        check("R6 coef_clr", coef_clr, 2'b11);
        bus_read(8'h85, d);
        check("R6 ch0 off5 default", d, 8'h85);
        bus_read(8'hFF, d);
        check("R6 ch1 off63 default", d, 8'hBF);
        bus_write(8'h85, 8'h77);
        bus_read(8'h85, d);
        check("R8 write ignored when busy", d, 8'h85);
        check("R11 bypass before strobe", bypass_on, 1);
        strobe();
        check("R11 bypass ends at first strobe", bypass_on, 0);
        check("R7 busy after first strobe", init_busy, 1);
        check("R10 rout from cancellers", rout, {8'hE1, 8'hE0});
        check("R10 sout from cancellers", sout, {8'hF1, 8'hF0});
        strobe();
        check("R7 busy ends on second strobe", init_busy, 0);
        check("R7 ch_active", ch_active, 2'b11);
        bus_write(8'h85, 8'h77);
        bus_read(8'h85, d);
        check("R8 write after init", d, 8'h77);
    endtask

    task automatic t_abort();
        bus_write(8'h00, 8'h00);
        idle(2);
        check("R9 ch_active drops", ch_active, 0);
        check("R9 bypass waits for strobe", bypass_on, 0);
        strobe();
        check("R9 bypass at strobe", bypass_on, 1);
        bus_write(8'h00, 8'h01);
        idle(2);
        strobe();
        check("R9 mid-init busy", init_busy, 1);
        bus_write(8'h00, 8'h00);
        idle(2);
        check("R9 abort clears busy", init_busy, 0);
        check("R9 abort no coef_clr", coef_clr, 0);
        strobe();
        check("R9 bypass after abort", bypass_on, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_fields();
        t_mask();
        t_bypass();
        t_window();
        t_powerup();
        t_abort();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule